// File: doc/BRIEF.md
# Parallel LVDS Cable Framer

This block carries fixed 65-bit frames across a 16-line parallel LVDS cable, one direction per framer. Each clock cycle puts one beat on the cable. A beat has 13 data lines, a carrier flag and a parity line, and the clock is forwarded on the remaining line. A frame takes five consecutive beats with the carrier raised. Between frames the cable carries idle beats with the carrier low, and the receiver uses these to find where each frame starts.

The transmit side takes frames on a valid/ready stream and only accepts one when the cable is idle. A frame that is still being sent back-pressures the sender by holding `tx_ready` low. The receive side rebuilds frames from the beats and checks parity on every data beat. It presents each good frame on a valid/ready stream. The frame is held with `rx_valid` high and `rx_data` stable until the consumer raises `rx_ready`. The receiver has no further storage. A frame that completes while the previous one is still unread is dropped and reported. Errors appear on `rx_err` as a one-cycle code.

Top module: `lvds_frame_link`

## Requirements
- R1: After the edge that accepts a frame (`tx_valid` and `tx_ready` both high), the next five cycles drive beats 0 to 4 with `lvds_tx_carrier`=1. Beat k carries frame bits [13k+12:13k], so bits [12:0] go out first.
- R2: `tx_ready` is high only while an idle beat is on the cable. An idle beat has carrier 0, data 0 and parity 0. At least one idle beat follows every frame. `tx_ready` rises in the cycle right after the fifth beat.
- R3: Every beat uses even parity. The XOR of the 13 data lines, the carrier line and the parity line is 0.
- R4: During reset the transmit lines show an idle beat, `tx_ready` is 1, `rx_valid` is 0 and `rx_err` is 00.
- R5: The receiver starts a frame only on a carrier=1 beat that directly follows a carrier=0 beat. Carrier=1 beats seen after reset before any idle, or seen after a fifth beat, are ignored.
- R6: When the fifth carrier=1 beat is sampled at an edge, `rx_valid` is high and `rx_data` holds the frame in the cycle after that edge. The beats go into `rx_data` at the same bit positions the transmitter takes them from.
- R7: If any data beat of a frame fails parity, the frame is discarded. `rx_err` reads 01 for the one cycle after the fifth beat.
- R8: If the carrier drops to 0 after one to four data beats, the partial frame is discarded. `rx_err` reads 10 for the one cycle after the edge that samples the low carrier.
- R9: While `rx_valid` is 1 and `rx_ready` is 0, `rx_data` stays unchanged. The frame leaves after an edge with `rx_ready` high. A frame that completes while the held frame is not being read is dropped, and `rx_err` reads 11. If the held frame is read on the same edge, the new frame is loaded instead.
- R10: `tx_data` is sampled only on the accepting edge. Changes to it while a frame is being sent do not affect the beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, one beat per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Frame offered for sending |
| tx_ready | output | 1 | Transmitter accepts a frame this cycle |
| tx_data | input | 65 | Frame to send |
| lvds_tx_data | output | 13 | Outgoing beat data lines |
| lvds_tx_carrier | output | 1 | Outgoing carrier flag (1 data, 0 idle) |
| lvds_tx_parity | output | 1 | Outgoing even parity line |
| lvds_rx_data | input | 13 | Incoming beat data lines |
| lvds_rx_carrier | input | 1 | Incoming carrier flag |
| lvds_rx_parity | input | 1 | Incoming parity line |
| rx_valid | output | 1 | Rebuilt frame available |
| rx_ready | input | 1 | Consumer takes the frame at this edge |
| rx_data | output | 65 | Rebuilt frame |
| rx_err | output | 2 | One-cycle code: 00 none, 01 parity, 10 truncated, 11 dropped |

## Verification
Beat k of a frame is due on the cable k+1 cycles after the accepting edge. A rebuilt frame or an error code is due one cycle after the edge that samples the deciding beat. The bench model advances once per falling edge, using the inputs the next rising edge will see. The model then states what every output must be after that edge, and the outputs are compared at the following falling edge. No comparison is ever made during the edge that changes a value. The receive lines are fed by looping back the transmit lines, either with bit flips and a forced-low carrier injected, or with beats the bench builds itself.

// File: rtl/lvds_link_pkg.sv
package lvds_link_pkg;
  typedef enum logic [1:0] {
    RXE_NONE    = 2'b00,
    RXE_PARITY  = 2'b01,
    RXE_TRUNC   = 2'b10,
    RXE_DROPPED = 2'b11
  } rx_err_e;
endpackage

// File: rtl/lvds_tx_framer.sv
module lvds_tx_framer #(
  parameter int BEAT_W = 13,
  parameter int BEATS  = 5,
  localparam int FRAME_W = BEAT_W * BEATS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [FRAME_W-1:0] in_data,
  output logic [BEAT_W-1:0]  beat_data,
  output logic               beat_carrier,
  output logic               beat_parity
);
  localparam int CNT_W = $clog2(BEATS + 1);

  logic [FRAME_W-1:0] pending;
  logic [CNT_W-1:0]   sent;
  logic [FRAME_W-1:0] src;

  // sent == 0: idle beat on the cable, open for a new frame
  assign in_ready = (sent == '0);
  assign src      = (sent == '0) ? in_data : pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending      <= '0;
      sent         <= '0;
      beat_data    <= '0;
      beat_carrier <= 1'b0;
      beat_parity  <= 1'b0;
    end else if ((sent == '0 && in_valid) || (sent != '0 && sent != CNT_W'(BEATS))) begin
      beat_data    <= src[BEAT_W-1:0];
      beat_carrier <= 1'b1;
      beat_parity  <= ^{src[BEAT_W-1:0], 1'b1};
      pending      <= src >> BEAT_W;
      sent         <= sent + 1'b1;
    end else if (sent == CNT_W'(BEATS)) begin
      beat_data    <= '0;
      beat_carrier <= 1'b0;
      beat_parity  <= 1'b0;
      sent         <= '0;
    end
  end
endmodule

// File: rtl/lvds_rx_framer.sv
module lvds_rx_framer
  import lvds_link_pkg::*;
#(
  parameter int BEAT_W = 13,
  parameter int BEATS  = 5,
  localparam int FRAME_W = BEAT_W * BEATS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BEAT_W-1:0]  beat_data,
  input  logic               beat_carrier,
  input  logic               beat_parity,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [FRAME_W-1:0] out_data,
  output logic [1:0]         out_err
);
  localparam int CNT_W = $clog2(BEATS + 1);

  logic               armed;
  logic [CNT_W-1:0]   got;
  logic               bad_so_far;
  logic [FRAME_W-1:0] asm_q;
  logic [FRAME_W-1:0] asm_next;
  logic               beat_bad;
  logic               frame_bad;
  logic               last_beat;
  logic               taken;

  assign beat_bad  = ^{beat_data, beat_carrier, beat_parity};
  assign frame_bad = bad_so_far | beat_bad;
  assign last_beat = (got == CNT_W'(BEATS - 1));
  assign taken     = out_valid & out_ready;
  // new beat enters at the top; after BEATS shifts beat 0 sits at the bottom
  assign asm_next  = {beat_data, asm_q[FRAME_W-1:BEAT_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      got        <= '0;
      bad_so_far <= 1'b0;
      asm_q      <= '0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_err    <= RXE_NONE;
    end else begin
      out_err <= RXE_NONE;
      if (taken) out_valid <= 1'b0;
      if (beat_carrier) begin
        armed <= 1'b0;
        if (got == '0) begin
          if (armed) begin
            asm_q      <= asm_next;
            got        <= CNT_W'(1);
            bad_so_far <= beat_bad;
          end
        end else if (last_beat) begin
          got        <= '0;
          bad_so_far <= 1'b0;
          if (frame_bad) begin
            out_err <= RXE_PARITY;
          end else if (out_valid && !out_ready) begin
            out_err <= RXE_DROPPED;
          end else begin
            out_valid <= 1'b1;
            out_data  <= asm_next;
          end
        end else begin
          asm_q      <= asm_next;
          got        <= got + 1'b1;
          bad_so_far <= frame_bad;
        end
      end else begin
        armed <= 1'b1;
        if (got != '0) begin
          got        <= '0;
          bad_so_far <= 1'b0;
          out_err    <= RXE_TRUNC;
        end
      end
    end
  end
endmodule

// File: rtl/lvds_frame_link.sv
module lvds_frame_link #(
  parameter int BEAT_W = 13,
  parameter int BEATS  = 5,
  localparam int FRAME_W = BEAT_W * BEATS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_valid,
  output logic               tx_ready,
  input  logic [FRAME_W-1:0] tx_data,
  output logic [BEAT_W-1:0]  lvds_tx_data,
  output logic               lvds_tx_carrier,
  output logic               lvds_tx_parity,
  input  logic [BEAT_W-1:0]  lvds_rx_data,
  input  logic               lvds_rx_carrier,
  input  logic               lvds_rx_parity,
  output logic               rx_valid,
  input  logic               rx_ready,
  output logic [FRAME_W-1:0] rx_data,
  output logic [1:0]         rx_err
);
  lvds_tx_framer #(.BEAT_W(BEAT_W), .BEATS(BEATS)) u_tx (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (tx_valid),
    .in_ready     (tx_ready),
    .in_data      (tx_data),
    .beat_data    (lvds_tx_data),
    .beat_carrier (lvds_tx_carrier),
    .beat_parity  (lvds_tx_parity)
  );

  lvds_rx_framer #(.BEAT_W(BEAT_W), .BEATS(BEATS)) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .beat_data    (lvds_rx_data),
    .beat_carrier (lvds_rx_carrier),
    .beat_parity  (lvds_rx_parity),
    .out_valid    (rx_valid),
    .out_ready    (rx_ready),
    .out_data     (rx_data),
    .out_err      (rx_err)
  );
endmodule

// File: rtl/lvds_frame_link_chk.sv
module lvds_frame_link_chk #(
  parameter int BEAT_W = 13,
  parameter int BEATS  = 5,
  localparam int FRAME_W = BEAT_W * BEATS
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tx_ready,
  input logic [BEAT_W-1:0]  lvds_tx_data,
  input logic               lvds_tx_carrier,
  input logic               lvds_tx_parity,
  input logic               rx_valid,
  input logic               rx_ready,
  input logic [FRAME_W-1:0] rx_data,
  input logic [1:0]         rx_err
);
  int unsigned run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= 0;
    else        run_len <= lvds_tx_carrier ? run_len + 1 : 0;
  end

  // R1: a carrier burst is exactly BEATS beats long
  assert_burst_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lvds_tx_carrier) |-> run_len == BEATS);

  // R2: the transmitter takes a frame only while idle is on the cable
  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !lvds_tx_carrier);

  // R3: every driven beat has even parity
  assert_even_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (^{lvds_tx_data, lvds_tx_carrier, lvds_tx_parity}) == 1'b0);

  // R9: a held frame stays put until taken
  assert_hold_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));

  // R8: error codes last one cycle
  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err != 2'b00 |=> rx_err == 2'b00);
endmodule

bind lvds_frame_link lvds_frame_link_chk #(.BEAT_W(BEAT_W), .BEATS(BEATS)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .tx_ready        (tx_ready),
  .lvds_tx_data    (lvds_tx_data),
  .lvds_tx_carrier (lvds_tx_carrier),
  .lvds_tx_parity  (lvds_tx_parity),
  .rx_valid        (rx_valid),
  .rx_ready        (rx_ready),
  .rx_data         (rx_data),
  .rx_err          (rx_err)
);

// File: tb/lvds_frame_link_tb.sv
module lvds_frame_link_tb;
  localparam int BW = 13;
  localparam int NB = 5;
  localparam int FW = BW * NB;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          tx_valid = 1'b0;
  logic          tx_ready;
  logic [FW-1:0] tx_data = '0;
  logic [BW-1:0] ltd;
  logic          ltc, ltp;
  logic [BW-1:0] lrd = '0;
  logic          lrc = 1'b0, lrp = 1'b0;
  logic          rx_valid;
  logic          rx_ready = 1'b1;
  logic [FW-1:0] rx_data;
  logic [1:0]    rx_err;

  lvds_frame_link u_dut (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .lvds_tx_data(ltd), .lvds_tx_carrier(ltc), .lvds_tx_parity(ltp),
    .lvds_rx_data(lrd), .lvds_rx_carrier(lrc), .lvds_rx_parity(lrp),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_err(rx_err)
  );

  // stimulus controls for the receive lines
  bit            bench_drive = 0;
  logic [BW-1:0] bd_d = '0;
  logic          bd_c = 1'b0;
  logic [BW-1:0] inj = '0;
  logic          kill = 1'b0;

  // reference model state
  int            ph;
  logic [FW-1:0] hold;
  bit            armed;
  int            n;
  bit            pb;
  logic [FW-1:0] acc;
  logic          ev;
  logic [FW-1:0] ed;
  logic [1:0]    ee;

  int    vectors = 0;
  int    errors  = 0;
  string req = "R4";
  bit    done = 0;

  task automatic chk(string field, logic [FW-1:0] act, logic [FW-1:0] exp);
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, field, act, exp);
    end
  endtask

  task automatic model_reset();
    ph = 0; hold = '0; armed = 0; n = 0; pb = 0; acc = '0; ev = 1'b0; ed = '0; ee = 2'b00;
  endtask

  task automatic compare();
    logic [BW-1:0] xd;
    logic          xc;
    vectors++;
    xd = '0; xc = 1'b0;
    if (ph >= 1 && ph <= NB) begin
      xd = hold[(ph-1)*BW +: BW];
      xc = 1'b1;
    end
    chk("tx_ready", FW'(tx_ready), FW'(ph == 0));
    chk("tx_data_lines", FW'(ltd), FW'(xd));
    chk("tx_carrier", FW'(ltc), FW'(xc));
    chk("tx_parity", FW'(ltp), FW'(^{xd, xc}));
    chk("rx_valid", FW'(rx_valid), FW'(ev));
    if (ev) chk("rx_data", rx_data, ed);
    chk("rx_err", FW'(rx_err), FW'(ee));
  endtask

  task automatic drive_rx();
    if (bench_drive) begin
      lrd = bd_d ^ inj; lrc = bd_c; lrp = ^{bd_d, bd_c};
    end else begin
      lrd = ltd ^ inj; lrc = ltc & ~kill; lrp = ltp;
    end
  endtask

  task automatic model_step();
    bit bad;
    bit was_valid;
    bit rd;
    // transmit side
    if (ph == 0) begin
      if (tx_valid) begin hold = tx_data; ph = 1; end
    end else if (ph == NB) ph = 0;
    else ph++;
    // receive side
    ee = 2'b00;
    was_valid = ev;
    rd = ev && rx_ready;
    if (rd) ev = 1'b0;
    bad = ^{lrd, lrc, lrp};
    if (lrc) begin
      if (n == 0) begin
        if (armed) begin acc[BW-1:0] = lrd; n = 1; pb = bad; end
      end else begin
        acc[n*BW +: BW] = lrd;
        pb = pb | bad;
        n++;
        if (n == NB) begin
          n = 0;
          if (pb) ee = 2'b01;
          else if (was_valid && !rd) ee = 2'b11;
          else begin ev = 1'b1; ed = acc; end
        end
      end
      armed = 0;
    end else begin
      if (n != 0) begin ee = 2'b10; n = 0; end
      armed = 1;
    end
  endtask

  task automatic step();
    compare();
    drive_rx();
    model_step();
    @(negedge clk);
  endtask

  // R4: hold reset for a few cycles and check the idle state
  task automatic reset_phase();
    string keep;
    keep = req;
    req = "R4";
    rst_n = 1'b0;
    model_reset();
    repeat (3) begin
      @(negedge clk);
      compare();
      drive_rx();
    end
    rst_n = 1'b1;
    req = keep;
    @(negedge clk);
    vectors++;
    drive_rx();
    model_step();
    @(negedge clk);
  endtask

  // launch one frame through loopback; inj_beat / kill_beat select faults
  task automatic send_frame(logic [FW-1:0] d, int inj_beat, int kill_beat, int ready_last);
    tx_valid = 1'b1;
    tx_data  = d;
    while (ph != 0) step();
    step();
    tx_valid = 1'b0;
    for (int b = 0; b < NB; b++) begin
      tx_data = ~d ^ FW'(b * 32'h1357);   // R10: disturb the input while sending
      inj  = (b == inj_beat) ? 13'h0040 : '0;
      kill = (b >= kill_beat);
      if (b == NB - 1 && ready_last >= 0) rx_ready = ready_last[0];
      step();
    end
    inj = '0;
    kill = 1'b0;
  endtask

  initial begin
    model_reset();
    @(negedge clk);
    reset_phase();

    req = "R1";   // R1, R3, R6: plain loopback
    send_frame(65'h1_2345_6789_ABCD_EF01, -1, NB, -1);
    step();
    req = "R2";   // R2: back-to-back offers, gaps enforced
    send_frame({65{1'b1}}, -1, NB, -1);
    send_frame({1'b0, {32{2'b10}}}, -1, NB, -1);
    for (int w = 0; w < 4; w++) send_frame(FW'(1) << (w * 17 + 3), -1, NB, -1);
    repeat (2) step();

    req = "R7";   // R7: flip a data line on beat 3
    send_frame(65'h0_DEAD_BEEF_CAFE_F00D, 3, NB, -1);
    send_frame(65'h1_0F0F_0F0F_0F0F_0F0F, 0, NB, -1);
    step();
    req = "R8";   // R8: carrier dropped after two beats, then after four
    send_frame(65'h0_1111_2222_3333_4444, -1, 2, -1);
    send_frame(65'h1_5555_6666_7777_8888, -1, 4, -1);
    send_frame(65'h0_9999_AAAA_BBBB_CCCC, -1, NB, -1);
    step();

    req = "R9";   // R9: hold, drop, and read on the completing edge
    rx_ready = 1'b0;
    send_frame(65'h1_AAAA_0000_5555_FFFF, -1, NB, -1);
    repeat (3) step();
    send_frame(65'h0_0123_4567_89AB_CDEF, -1, NB, -1);
    send_frame(65'h1_FEDC_BA98_7654_3210, -1, NB, 1);
    rx_ready = 1'b1;
    repeat (3) step();

    req = "R5";   // R5: seven carrier beats, only the first five form a frame
    bench_drive = 1;
    bd_c = 1'b0; step(); step();
    for (int b = 0; b < 7; b++) begin
      bd_c = 1'b1; bd_d = BW'(b * 13'h0123 + 13'h0055);
      step();
    end
    bd_c = 1'b0; bd_d = '0;
    repeat (2) step();
    // R5: carrier high straight out of reset is ignored until an idle beat
    bd_c = 1'b1; bd_d = 13'h1ABC;
    reset_phase();
    for (int b = 0; b < NB; b++) begin bd_d = BW'(b + 13'h0700); step(); end
    bd_c = 1'b0; step();
    for (int b = 0; b < NB; b++) begin bd_c = 1'b1; bd_d = BW'(b * 13'h0401); step(); end
    bd_c = 1'b0; bd_d = '0;
    repeat (3) step();
    bench_drive = 0;

    req = "R10";  // R10: final loopback frame with a changing input
    send_frame(65'h0_5A5A_A5A5_C3C3_3C3C, -1, NB, -1);
    repeat (3) step();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule